// File: doc/BRIEF.md
# Slot-Table Downlink Quota Scheduler

The scheduler decides which of six instrument input ports supplies each outgoing frame on a fixed-rate science downlink. A rewritable table of `NUM_SLOTS` entries, 1300 by default, is walked in a circle. Each entry holds a 3-bit source code. Each output frame takes one slot of 16352 bits, about 109 us at 150 Mbps. With roughly 130 Mbps of payload spread over 1300 slots, every entry assigned to a port gives that port 0.1 Mbps of downlink. The number of entries a port holds is therefore its bandwidth cap.

After every reset the table is filled from a computed default image, one entry per clock. Ground commands can then rewrite single entries. On each slot strobe the block emits a one-cycle grant that carries the chosen code and the slot index. If the named port has no complete frame ready, the grant becomes fill. The slot is never handed to another port.

Top module: `tdm_slot_sched`

## Requirements
- R1: While `rst_ni` is low, `grant_valid_o` is 0. After release, the table is loaded in `NUM_SLOTS` clock cycles with the default image: slot i holds code (i mod 8).
- R2: A strobe that arrives while the load is running produces a grant with code 7 (fill) and slot index 0, and the cursor does not move. A command write that arrives during the load is discarded.
- R3: A strobe `slot_tick_i` sampled high at a clock edge produces `grant_valid_o` high for exactly the following cycle. That grant carries the current slot index, and the cursor then advances by one.
- R4: After slot `NUM_SLOTS`-1 the cursor wraps to slot 0 with no gap.
- R5: Codes 0 to 5 name ports 0 to 5 (bit n of `port_ready_i` is port n). When the named port is ready at the strobe, the grant code is that port; otherwise the grant code is 7. No other port is substituted.
- R6: A table code of 6 or 7 always produces grant code 7, and the grant code is never 6.
- R7: A command write (`cmd_we_i`, `cmd_addr_i`, `cmd_code_i`) replaces one slot, and later passes use the new value. A write to the slot being granted in the same cycle leaves that grant with the old code and takes effect on the next pass.
- R8: A command write with `cmd_addr_i` >= `NUM_SLOTS` changes no slot.
- R9: `grant_valid_o` is never high in a cycle that does not follow a sampled strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | Slot boundary strobe |
| port_ready_i | input | 6 | Per-port complete-frame-ready flags |
| cmd_we_i | input | 1 | Command write enable |
| cmd_addr_i | input | IDX_W | Command slot address |
| cmd_code_i | input | 3 | Command slot code |
| grant_valid_o | output | 1 | Grant strobe, one cycle |
| grant_code_o | output | 3 | Granted port code, 7 = fill |
| grant_slot_o | output | IDX_W | Slot index of this grant |

## Verification
The bench runs a 24-slot table through whole passes with all ports ready, with none ready, and with a walking ready pattern. Every grant is compared with an arithmetic model of the default image. Passes that are too few, or that wrap wrongly, would show as a slot index that drifts from the model.

The bench also strobes during the load and writes a command during the load. A design that serves the half-loaded table, or keeps the early write, would give a non-fill grant or a changed slot 5.

A write to the slot being granted, made in that same cycle, must leave the current grant with its old code. A design with a write-through read would expose the new code one pass early.

Out-of-range addresses are written and then checked over a whole pass, so an address that aliases onto another slot would be caught. A reset during a run must bring back the defaults.

// File: rtl/tdm_sched_pkg.sv
package tdm_sched_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_PORTS = 6;

  typedef logic [CODE_W-1:0]    code_t;
  typedef logic [NUM_PORTS-1:0] ready_t;

  localparam code_t FILL_CODE = code_t'(7);

  // default image, computed rather than stored
  function automatic code_t default_code(input int unsigned idx);
    return code_t'(idx % 8);
  endfunction

  // a slot whose port is not ready becomes fill, never another port
  function automatic code_t resolve(input code_t c, input ready_t rdy);
    code_t r;
    r = FILL_CODE;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (c == code_t'(p) && rdy[p]) r = c;
    end
    return r;
  endfunction
endpackage

// File: rtl/tdm_init_seq.sv
module tdm_init_seq
  import tdm_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 1300,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             busy_o,
  output logic [IDX_W-1:0] wr_addr_o,
  output code_t            wr_code_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign wr_addr_o = cnt_q;
  assign wr_code_o = default_code(32'(cnt_q));
endmodule

// File: rtl/tdm_slot_ram.sv
module tdm_slot_ram
  import tdm_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 1300,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  code_t            wr_code_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output code_t            rd_code_o
);
  code_t mem_q [NUM_SLOTS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_addr_i] <= wr_code_i;
  end

  // read sees the value before any same-edge write
  assign rd_code_o = mem_q[rd_addr_i];
endmodule

// File: rtl/tdm_slot_cursor.sv
module tdm_slot_cursor #(
  parameter int NUM_SLOTS = 1300,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        idx_q <= '0;
    else if (advance_i) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/tdm_slot_sched.sv
module tdm_slot_sched
  import tdm_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 1300,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_tick_i,
  input  logic [5:0]       port_ready_i,
  input  logic             cmd_we_i,
  input  logic [IDX_W-1:0] cmd_addr_i,
  input  logic [2:0]       cmd_code_i,
  output logic             grant_valid_o,
  output logic [2:0]       grant_code_o,
  output logic [IDX_W-1:0] grant_slot_o
);
  localparam logic [IDX_W:0] SLOT_LIM = (IDX_W+1)'(NUM_SLOTS);

  logic             init_busy;
  logic [IDX_W-1:0] init_addr;
  code_t            init_code;
  logic [IDX_W-1:0] cur_idx;
  code_t            rd_code;
  logic             cmd_ok;
  logic             ram_we;
  logic [IDX_W-1:0] ram_addr;
  code_t            ram_code;
  logic             advance;

  tdm_init_seq #(.NUM_SLOTS(NUM_SLOTS)) u_init (
    .clk_i, .rst_ni,
    .busy_o(init_busy), .wr_addr_o(init_addr), .wr_code_o(init_code)
  );

  // load owns the write port; commands outside the table are dropped
  assign cmd_ok   = cmd_we_i && !init_busy && ({1'b0, cmd_addr_i} < SLOT_LIM);
  assign ram_we   = init_busy || cmd_ok;
  assign ram_addr = init_busy ? init_addr : cmd_addr_i;
  assign ram_code = init_busy ? init_code : code_t'(cmd_code_i);

  tdm_slot_ram #(.NUM_SLOTS(NUM_SLOTS)) u_ram (
    .clk_i, .we_i(ram_we), .wr_addr_i(ram_addr), .wr_code_i(ram_code),
    .rd_addr_i(cur_idx), .rd_code_o(rd_code)
  );

  assign advance = slot_tick_i && !init_busy;

  tdm_slot_cursor #(.NUM_SLOTS(NUM_SLOTS)) u_cursor (
    .clk_i, .rst_ni, .advance_i(advance), .idx_o(cur_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_code_o  <= FILL_CODE;
      grant_slot_o  <= '0;
    end else begin
      grant_valid_o <= slot_tick_i;
      if (slot_tick_i) begin
        if (init_busy) begin
          grant_code_o <= FILL_CODE;
          grant_slot_o <= '0;
        end else begin
          grant_code_o <= resolve(rd_code, port_ready_i);
          grant_slot_o <= cur_idx;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_sched_chk.sv
module tdm_slot_sched_chk #(
  parameter int NUM_SLOTS = 1300,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             slot_tick_i,
  input logic [5:0]       port_ready_i,
  input logic             grant_valid_o,
  input logic [2:0]       grant_code_o,
  input logic [IDX_W-1:0] grant_slot_o,
  input logic             init_busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SLOTS - 1);

  logic [5:0]       rdy_q;
  logic             have_prev_q;
  logic [IDX_W-1:0] prev_slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q       <= '0;
      have_prev_q <= 1'b0;
      prev_slot_q <= '0;
    end else begin
      rdy_q <= port_ready_i;
      if (grant_valid_o && !$past(init_busy)) begin
        have_prev_q <= 1'b1;
        prev_slot_q <= grant_slot_o;
      end
    end
  end

  a_r9_grant_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> $past(slot_tick_i));

  a_r6_never_code_six: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> grant_code_o != 3'd6);

  a_r5_port_was_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && grant_code_o < 3'd6) |-> rdy_q[grant_code_o]);

  a_r2_fill_during_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && $past(init_busy)) |-> (grant_code_o == 3'd7 && grant_slot_o == '0));

  a_r4_slot_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ({1'b0, grant_slot_o} < (IDX_W+1)'(NUM_SLOTS)));

  a_r3_slot_sequence: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o && !$past(init_busy) && have_prev_q) |->
      grant_slot_o == ((prev_slot_q == LAST) ? '0 : prev_slot_q + 1'b1));
endmodule

bind tdm_slot_sched tdm_slot_sched_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .slot_tick_i(slot_tick_i),
  .port_ready_i(port_ready_i), .grant_valid_o(grant_valid_o),
  .grant_code_o(grant_code_o), .grant_slot_o(grant_slot_o),
  .init_busy(init_busy)
);

// File: tb/tdm_slot_sched_tb.sv
module tdm_slot_sched_tb_top;
  localparam int NS = 24;
  localparam int IW = $clog2(NS);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          slot_tick_i = 1'b0;
  logic [5:0]    port_ready_i = '0;
  logic          cmd_we_i = 1'b0;
  logic [IW-1:0] cmd_addr_i = '0;
  logic [2:0]    cmd_code_i = '0;
  logic          grant_valid_o;
  logic [2:0]    grant_code_o;
  logic [IW-1:0] grant_slot_o;

  int vectors = 0;
  int errors  = 0;
  int exp_tab [NS];
  int exp_idx = 0;

  always #5 clk_i = ~clk_i;

  tdm_slot_sched #(.NUM_SLOTS(NS)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_res(input int c, input logic [5:0] r);
    if (c < 6 && r[c]) return c;
    return 7;
  endfunction

  task automatic load_defaults();
    for (int i = 0; i < NS; i++) exp_tab[i] = i % 8;
    exp_idx = 0;
  endtask

  // strobe one slot, optional command in the same cycle, check grant
  task automatic tick(input logic [5:0] rdy, input logic we, input int addr,
                      input int code, input string req);
    int ec;
    @(negedge clk_i);
    slot_tick_i  = 1'b1;
    port_ready_i = rdy;
    cmd_we_i     = we;
    cmd_addr_i   = IW'(addr);
    cmd_code_i   = 3'(code);
    @(negedge clk_i);
    slot_tick_i = 1'b0;
    cmd_we_i    = 1'b0;
    ec = exp_res(exp_tab[exp_idx], rdy);
    chk({req, " valid"}, int'(grant_valid_o), 1);
    chk({req, " code"},  int'(grant_code_o), ec);
    chk({req, " slot"},  int'(grant_slot_o), exp_idx);
    if (we && addr < NS) exp_tab[addr] = code;
    exp_idx = (exp_idx == NS - 1) ? 0 : exp_idx + 1;
  endtask

  task automatic cmd_write(input int addr, input int code);
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_addr_i = IW'(addr); cmd_code_i = 3'(code);
    @(negedge clk_i);
    cmd_we_i = 1'b0;
    if (addr < NS) exp_tab[addr] = code;
  endtask

  task automatic pass(input logic [5:0] rdy, input string req);
    for (int i = 0; i < NS; i++) tick(rdy, 1'b0, 0, 0, req);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 reset valid low", int'(grant_valid_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    load_defaults();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    load_defaults();
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid low", int'(grant_valid_o), 0);
    rst_ni = 1'b1;
    // R2: strobe and command during the load
    @(negedge clk_i);
    slot_tick_i = 1'b1; port_ready_i = '1;
    cmd_we_i = 1'b1; cmd_addr_i = IW'(5); cmd_code_i = 3'd0;
    @(negedge clk_i);
    slot_tick_i = 1'b0; cmd_we_i = 1'b0;
    chk("R2 load grant valid", int'(grant_valid_o), 1);
    chk("R2 load grant fill",  int'(grant_code_o), 7);
    chk("R2 load grant slot",  int'(grant_slot_o), 0);
    repeat (NS + 4) @(negedge clk_i);
    chk("R9 no grant idle", int'(grant_valid_o), 0);

    // R1 R3 R4 R6: full pass all ready, then wrap into the next pass
    pass(6'b111111, "R1 default all ready");
    tick(6'b111111, 1'b0, 0, 0, "R4 wrap");
    for (int i = 1; i < NS; i++) tick(6'b000000, 1'b0, 0, 0, "R5 none ready");
    // R5: walking ready bit, only the named port may be served
    for (int i = 0; i < NS; i++) tick(6'(1 << (i % 6)), 1'b0, 0, 0, "R5 walking ready");
    for (int i = 0; i < NS; i++) tick(6'b010101, 1'b0, 0, 0, "R5 partial ready");
    @(negedge clk_i);
    chk("R9 no grant after pass", int'(grant_valid_o), 0);

    // R7: rewrite slots including codes 6 and 7
    cmd_write(0, 6);
    cmd_write(1, 4);
    cmd_write(NS - 1, 0);
    cmd_write(7, 3);
    // R8: out-of-range addresses
    for (int a = NS; a < (1 << IW); a++) cmd_write(a, 1);
    pass(6'b111111, "R7 rewritten table");
    // R7: write the slot being granted in the same cycle
    for (int i = 0; i < 10; i++) tick(6'b111111, 1'b0, 0, 0, "R7 approach");
    tick(6'b111111, 1'b1, 10, 3, "R7 same slot old code");
    for (int i = 11; i < NS; i++) tick(6'b111111, 1'b0, 0, 0, "R7 rest");
    pass(6'b111111, "R7 same slot next pass");
    pass(6'b111111, "R8 table unchanged");

    // R1: reset during run restores defaults
    for (int i = 0; i < 5; i++) tick(6'b111111, 1'b0, 0, 0, "R3 mid run");
    do_reset();
    repeat (NS + 2) @(negedge clk_i);
    pass(6'b111111, "R1 defaults after reset");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule